// File: doc/BRIEF.md
# Clock Lane HS Burst Sequencer

This block steps the clock lane of a source-synchronous serial link through one high-speed burst and back to idle. It does no analog work. It only decides which line state the lane should be in and counts how long each state lasts, in cycles of one reference clock. The output is a 3-bit lane state code. A separate driver turns that code into line levels.

When a burst request is taken in idle, the lane leaves LP-11. It passes through LP-01 and then LP-00, then drives HS-0, and then starts toggling the high-speed clock. After a set number of toggling cycles it raises `clk_ready_o`. The data lane logic waits for this signal before it starts its own entry into high speed. When the data lanes report that they are back in low power, the clock goes on toggling for a post interval. It then drives HS-0 for a trail interval and returns to LP-11, where it stays for one LP length before it can take a new request.

Every interval length is captured from the configuration inputs at the moment the request is taken. A monitor measures the time from the start of the trail to the start of LP-11 against an end-of-transmission limit. If the limit is exceeded, it sets a sticky error flag.

Top module: `clk_lane_seq`

## Requirements
- R1: While `rst_ni` is low, and in idle, `lane_state_o` is 0 (LP-11) and `clk_ready_o` and `eot_err_o` are 0. With no request, the lane stays at code 0.
- R2: After a request is taken, the lane shows code 1 (LP-01) for the LP length, then code 2 (LP-00) for the prepare length, then code 3 (HS-0) for the zero length.
- R3: After HS-0, the lane shows code 4 (HS clock toggling) for the pre length with `clk_ready_o` low. `clk_ready_o` then rises while the code stays 4.
- R4: `clk_ready_o` stays high, with code 4, until `data_done_i` is sampled high. From the next cycle the lane keeps code 4 with `clk_ready_o` low for the post length.
- R5: After the post interval, the lane shows code 3 for the trail length. It then shows code 0 for the LP length before it returns to idle.
- R6: All interval lengths and the end-of-transmission limit are captured when the request is taken. Changes to the configuration inputs during a burst have no effect on that burst.
- R7: A configured length of zero gives a state that lasts exactly one cycle.
- R8: `burst_req_i` is ignored in every state except idle, including the closing LP-11 interval. `data_done_i` is ignored while `clk_ready_o` is low.
- R9: `eot_err_o` rises when the trail lasts more cycles than the end-of-transmission limit, with a limit of zero counted as one. Once set it stays high, and only reset clears it.
- R10: A request sampled high at a clock edge in idle makes the lane show code 1 from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_req_i | input | 1 | Burst request, taken in idle |
| data_done_i | input | 1 | Data lanes are back in low power |
| cfg_lpx_i | input | CW | LP state length, in cycles |
| cfg_prepare_i | input | CW | LP-00 length before HS-0, in cycles |
| cfg_zero_i | input | CW | HS-0 length before toggling, in cycles |
| cfg_pre_i | input | CW | Toggling length before clock ready, in cycles |
| cfg_post_i | input | CW | Toggling length after data done, in cycles |
| cfg_trail_i | input | CW | HS-0 trail length, in cycles |
| cfg_eot_i | input | CW | Limit from trail start to LP-11, in cycles |
| lane_state_o | output | 3 | Lane state code (0 LP-11, 1 LP-01, 2 LP-00, 3 HS-0, 4 toggling) |
| clk_ready_o | output | 1 | Data lanes may begin HS entry |
| eot_err_o | output | 1 | Sticky end-of-transmission violation |

## Verification
The properties assume that `data_done_i` matters only inside the clock-ready window, and that the lane's codes therefore follow one fixed order whatever the two control inputs do. The stimulus raises `data_done_i` exactly once per ready window, on the cycle chosen to end it. In some bursts it also drives stray requests, stray done pulses and changing configuration values in every other cycle. The trail and limit values are chosen so that some bursts stay within the limit and others exceed it.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;
  localparam logic [2:0] LS_LP11 = 3'd0;
  localparam logic [2:0] LS_LP01 = 3'd1;
  localparam logic [2:0] LS_LP00 = 3'd2;
  localparam logic [2:0] LS_HS0  = 3'd3;
  localparam logic [2:0] LS_TOG  = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_LP01, S_LP00, S_ZERO, S_PRE, S_RUN, S_POST, S_TRAIL, S_EXIT
  } seq_e;
endpackage

// File: rtl/lane_timer.sv
module lane_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  // zero-length interval behaves as one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= (val_i == '0) ? '0 : val_i - 1'b1;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/eot_mon.sv
module eot_mon #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trail_i,
  input  logic [CW-1:0] lim_i,
  output logic          err_o
);
  localparam int EW = CW + 1;
  logic [EW-1:0] cnt_q;
  logic [EW-1:0] cnt_inc;
  logic [EW-1:0] lim_eff;

  assign cnt_inc = cnt_q + 1'b1;
  assign lim_eff = (lim_i == '0) ? EW'(1) : {1'b0, lim_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_o <= 1'b0;
    end else if (trail_i) begin
      cnt_q <= cnt_inc;
      if (cnt_inc > lim_eff) err_o <= 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/clk_lane_seq.sv
module clk_lane_seq
  import clk_lane_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          burst_req_i,
  input  logic          data_done_i,
  input  logic [CW-1:0] cfg_lpx_i,
  input  logic [CW-1:0] cfg_prepare_i,
  input  logic [CW-1:0] cfg_zero_i,
  input  logic [CW-1:0] cfg_pre_i,
  input  logic [CW-1:0] cfg_post_i,
  input  logic [CW-1:0] cfg_trail_i,
  input  logic [CW-1:0] cfg_eot_i,
  output logic [2:0]    lane_state_o,
  output logic          clk_ready_o,
  output logic          eot_err_o
);
  seq_e st_q, st_d;
  logic [CW-1:0] lpx_q, prep_q, zero_q, pre_q, post_q, trail_q, eot_q;
  logic [CW-1:0] load_val;
  logic          load, expired, accept;

  assign accept = (st_q == S_IDLE) && burst_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lpx_q   <= '0;
      prep_q  <= '0;
      zero_q  <= '0;
      pre_q   <= '0;
      post_q  <= '0;
      trail_q <= '0;
      eot_q   <= '0;
    end else if (accept) begin
      lpx_q   <= cfg_lpx_i;
      prep_q  <= cfg_prepare_i;
      zero_q  <= cfg_zero_i;
      pre_q   <= cfg_pre_i;
      post_q  <= cfg_post_i;
      trail_q <= cfg_trail_i;
      eot_q   <= cfg_eot_i;
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (accept)      st_d = S_LP01;
      S_LP01:  if (expired)     st_d = S_LP00;
      S_LP00:  if (expired)     st_d = S_ZERO;
      S_ZERO:  if (expired)     st_d = S_PRE;
      S_PRE:   if (expired)     st_d = S_RUN;
      S_RUN:   if (data_done_i) st_d = S_POST;
      S_POST:  if (expired)     st_d = S_TRAIL;
      S_TRAIL: if (expired)     st_d = S_EXIT;
      S_EXIT:  if (expired)     st_d = S_IDLE;
      default:                  st_d = S_IDLE;
    endcase
  end

  // length of the state being entered
  always_comb begin
    unique case (st_d)
      S_LP01:  load_val = cfg_lpx_i;
      S_LP00:  load_val = prep_q;
      S_ZERO:  load_val = zero_q;
      S_PRE:   load_val = pre_q;
      S_POST:  load_val = post_q;
      S_TRAIL: load_val = trail_q;
      S_EXIT:  load_val = lpx_q;
      default: load_val = '0;
    endcase
  end

  assign load = (st_d != st_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;
  end

  lane_timer #(.CW(CW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .val_i    (load_val),
    .expired_o(expired)
  );

  eot_mon #(.CW(CW)) u_eot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trail_i(st_q == S_TRAIL),
    .lim_i  (eot_q),
    .err_o  (eot_err_o)
  );

  always_comb begin
    unique case (st_q)
      S_LP01:                lane_state_o = LS_LP01;
      S_LP00:                lane_state_o = LS_LP00;
      S_ZERO, S_TRAIL:       lane_state_o = LS_HS0;
      S_PRE, S_RUN, S_POST:  lane_state_o = LS_TOG;
      default:               lane_state_o = LS_LP11;
    endcase
  end

  assign clk_ready_o = (st_q == S_RUN);
endmodule

// File: rtl/clk_lane_chk.sv
module clk_lane_chk
  import clk_lane_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       burst_req_i,
  input logic [2:0] lane_state_o,
  input logic       clk_ready_o,
  input logic       eot_err_o
);
  a_r1_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_state_o == LS_LP11 && !burst_req_i) |=> lane_state_o == LS_LP11);

  a_r2_lp01_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_state_o == LS_LP01 |=> (lane_state_o == LS_LP01 || lane_state_o == LS_LP00));

  a_r2_lp00_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_state_o == LS_LP00 |=> (lane_state_o == LS_LP00 || lane_state_o == LS_HS0));

  a_r3_ready_after_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_ready_o) |-> $past(lane_state_o) == LS_TOG);

  a_r4_ready_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_ready_o |-> lane_state_o == LS_TOG);

  a_r4_post_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_ready_o |=> lane_state_o == LS_TOG);

  a_r5_toggle_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_state_o == LS_TOG |=> (lane_state_o == LS_TOG || lane_state_o == LS_HS0));

  a_r8_exit_ignores_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_state_o == LS_LP11 && $past(lane_state_o) == LS_HS0) |=> lane_state_o == LS_LP11);

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_err_o |=> eot_err_o);
endmodule

bind clk_lane_seq clk_lane_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .burst_req_i (burst_req_i),
  .lane_state_o(lane_state_o),
  .clk_ready_o (clk_ready_o),
  .eot_err_o   (eot_err_o)
);

// File: tb/sim_clk_lane_seq.sv
module sim_clk_lane_seq;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, done = 1'b0;
  logic [CW-1:0] c_lpx = '0, c_prep = '0, c_zero = '0, c_pre = '0;
  logic [CW-1:0] c_post = '0, c_trail = '0, c_eot = '0;
  logic [2:0]    lane;
  logic          ready, err;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  bit exp_err = 1'b0;

  int    q_st[$];
  int    q_rdy[$];
  string q_tag[$];

  always #10 clk = ~clk;

  clk_lane_seq #(.CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .burst_req_i(req), .data_done_i(done),
    .cfg_lpx_i(c_lpx), .cfg_prepare_i(c_prep), .cfg_zero_i(c_zero),
    .cfg_pre_i(c_pre), .cfg_post_i(c_post), .cfg_trail_i(c_trail),
    .cfg_eot_i(c_eot), .lane_state_o(lane), .clk_ready_o(ready),
    .eot_err_o(err)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int eff(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic add(int st, int rdy, string tag, int n);
    for (int i = 0; i < n; i++) begin
      q_st.push_back(st);
      q_rdy.push_back(rdy);
      q_tag.push_back(tag);
    end
  endtask

  task automatic burst(int lpx, int prep, int zero, int pre, int run,
                       int post, int trail, int eot, bit noise);
    int seen;
    q_st.delete(); q_rdy.delete(); q_tag.delete();
    add(1, 0, "R10", 1);
    add(1, 0, "R2", eff(lpx) - 1);
    add(2, 0, "R2", eff(prep));
    add(3, 0, "R2", eff(zero));
    add(4, 0, "R3", eff(pre));
    add(4, 1, "R4", run);
    add(4, 0, "R4", eff(post));
    add(3, 0, "R5", eff(trail));
    add(0, 0, "R5", eff(lpx));
    if (eff(trail) > eff(eot)) exp_err = 1'b1;
    @(negedge clk);
    c_lpx = CW'(lpx); c_prep = CW'(prep); c_zero = CW'(zero); c_pre = CW'(pre);
    c_post = CW'(post); c_trail = CW'(trail); c_eot = CW'(eot);
    req = 1'b1; done = 1'b0;
    seen = 0;
    for (int k = 0; k < q_st.size(); k++) begin
      @(negedge clk);
      check({q_tag[k], noise ? " R6 R8 R7" : " R7", " lane"}, int'(lane), q_st[k]);
      check({q_tag[k], " ready"}, int'(ready), q_rdy[k]);
      req = noise;
      if (q_rdy[k] == 1) begin
        seen++;
        done = (seen == run);
      end else begin
        done = noise;
      end
      if (noise) begin
        c_lpx = CW'($urandom_range(0, 9)); c_prep = CW'($urandom_range(0, 9));
        c_zero = CW'($urandom_range(0, 9)); c_pre = CW'($urandom_range(0, 9));
        c_post = CW'($urandom_range(0, 9)); c_trail = CW'($urandom_range(0, 9));
        c_eot = CW'($urandom_range(0, 9));
      end
    end
    req = 1'b0; done = 1'b0;
    @(negedge clk);
    check("R1 idle lane", int'(lane), 0);
    check("R1 idle ready", int'(ready), 0);
    check("R9 err", int'(err), int'(exp_err));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset lane", int'(lane), 0);
    check("R1 reset ready", int'(ready), 0);
    check("R1 reset err", int'(err), 0);
    rst_n = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check("R1 idle no req", int'(lane), 0);
    end
    done = 1'b1;
    @(negedge clk);
    check("R8 done in idle", int'(lane), 0);
    done = 1'b0;

    burst(3, 2, 4, 5, 3, 2, 3, 6, 1'b0);
    burst(0, 0, 0, 0, 1, 0, 0, 0, 1'b0);
    burst(2, 3, 1, 4, 6, 3, 2, 5, 1'b1);
    burst(1, 1, 1, 1, 2, 1, 1, 1, 1'b1);
    burst(2, 1, 2, 2, 1, 2, 5, 3, 1'b0);
    burst(1, 2, 1, 3, 2, 1, 1, 9, 1'b0);
    burst(4, 1, 3, 2, 4, 5, 0, 0, 1'b1);

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 err cleared by reset", int'(err), 0);
    check("R1 lane in reset", int'(lane), 0);
    exp_err = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    burst(2, 2, 2, 2, 2, 2, 2, 2, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule